// File: doc/BRIEF.md
# External Interrupt Request Latch

This block captures external interrupt requests for a small 8-bit microcontroller. One dedicated active-low interrupt pin is always a request source. When a configuration bit allows it, four active-low port pins join it. All of them are synchronised and merged through a single OR into one request. That request sets a single pending latch. The latch fires on a falling edge of the merged request. A second configuration bit adds level triggering, so a request that is still held keeps the latch set.

The CPU sees three things. The first is the pending flag. The second is a request that is gated by a local enable bit and by the CPU's global interrupt mask. The third is the fixed address pair of the service vector. The latch clears on reset, during the vector fetch, and when software writes a one to the acknowledge bit. A new request can therefore be captured while the service routine runs. The synchronised level of the dedicated pin is also exported, so that branch-on-pin instructions can test it. Register decoding, the CPU and the option storage sit outside the block and reach it only as strobes and configuration bits.

Top module: `xirq_capture`

## Requirements
- R1: After reset, irq_pending, cpu_irq_req and irq_take are 0 and the enable bit (ctl_rdata[7]) is 0.
- R2: A falling edge on irq_pin_n sets irq_pending on the third rising clock edge after the pin changes, and not before.
- R3: When cfg_port_en is 0, the port pins have no effect on irq_pending. When it is 1, a low level on any one of them is a request in the same way as a low irq_pin_n.
- R4: With cfg_level_mode = 0, a request that stays low after the latch is cleared does not set it again. Only a fresh falling edge does.
- R5: With cfg_level_mode = 1, irq_pending stays at 1 through a clear for as long as the merged request stays low.
- R6: cpu_irq_req is 1 exactly when irq_pending is 1, the enable bit is 1 and cpu_imask is 0. irq_take is cpu_irq_req qualified by cpu_boundary.
- R7: A vector_fetch pulse, or a ctl_wr with ctl_wdata_ack = 1, clears irq_pending on the next clock. A set that occurs in the same cycle wins over the clear.
- R8: ctl_rdata bit 7 holds the enable bit (loaded from ctl_wdata_en on ctl_wr) and bit 3 holds the pending flag. Every other bit, including the acknowledge bit 2, reads 0.
- R9: vec_addr_hi is 0x7FA and vec_addr_lo is 0x7FB.
- R10: pin_level follows irq_pin_n after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low |
| port_pin_n | input | 4 | Port pins usable as request sources, active low |
| cfg_port_en | input | 1 | Adds the port pins to the OR |
| cfg_level_mode | input | 1 | 1: edge and level trigger, 0: edge only |
| ctl_wr | input | 1 | Write strobe for the status/control register |
| ctl_wdata_en | input | 1 | Enable bit value written on ctl_wr |
| ctl_wdata_ack | input | 1 | Acknowledge bit written on ctl_wr; a 1 clears the latch |
| vector_fetch | input | 1 | CPU is fetching this interrupt's vector |
| cpu_imask | input | 1 | CPU global interrupt mask |
| cpu_boundary | input | 1 | CPU is at an instruction boundary |
| irq_pending | output | 1 | Latch state |
| cpu_irq_req | output | 1 | Gated request to the CPU |
| irq_take | output | 1 | Request accepted at an instruction boundary |
| ctl_rdata | output | 8 | Status/control read value |
| vec_addr_hi | output | 11 | Vector high-byte address |
| vec_addr_lo | output | 11 | Vector low-byte address |
| pin_level | output | 1 | Synchronised level of irq_pin_n |

## Verification
A pin change reaches pin_level two clock edges after it is driven. It reaches irq_pending on the third edge. The gated request and the read value follow the latch with no added delay. A clear from a fetch or an acknowledge takes effect on the next edge. The bench drives every input on the falling clock edge and counts rising edges before it samples on a falling edge. It also samples the pending flag one edge before the change is due, to show that no stage has been skipped or added. The set-wins-over-clear check lines up an acknowledge with the edge on which the delayed falling edge reaches the latch.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned CTL_W        = 8;
  localparam int unsigned CTL_EN_BIT   = 7;
  localparam int unsigned CTL_PEND_BIT = 3;
  localparam int unsigned CTL_ACK_BIT  = 2;
  localparam int unsigned VEC_W        = 11;
  localparam logic [VEC_W-1:0] VEC_BASE = 11'h7FA;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_EDGE_LEVEL = 1'b1} trig_mode_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/xirq_merge.sv
module xirq_merge #(
  parameter int unsigned NPORT = 4
) (
  input  logic             pin_n,
  input  logic [NPORT-1:0] port_n,
  input  logic             port_en,
  output logic             req_act
);
  logic port_act;

  always_comb begin
    port_act = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      port_act = port_act | ~port_n[i];
    end
    req_act = ~pin_n | (port_en & port_act);
  end
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_act,
  input  trig_mode_e mode,
  input  logic       clr,
  output logic       pending
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic fall_evt, set_evt;

  always_comb begin
    fall_evt = req_act & ~prev_q;
    set_evt  = fall_evt | ((mode == TRIG_EDGE_LEVEL) & req_act);
    prev_d   = req_act;
    if (set_evt)  pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
    else          pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/xirq_capture.sv
module xirq_capture
  import xirq_pkg::*;
#(
  parameter int unsigned NPORT       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pin_n,
  input  logic             cfg_port_en,
  input  logic             cfg_level_mode,
  input  logic             ctl_wr,
  input  logic             ctl_wdata_en,
  input  logic             ctl_wdata_ack,
  input  logic             vector_fetch,
  input  logic             cpu_imask,
  input  logic             cpu_boundary,
  output logic             irq_pending,
  output logic             cpu_irq_req,
  output logic             irq_take,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [VEC_W-1:0] vec_addr_hi,
  output logic [VEC_W-1:0] vec_addr_lo,
  output logic             pin_level
);
  localparam int unsigned SW = NPORT + 1;

  logic [SW-1:0] raw_n, sync_n;
  logic          comb_act;
  logic          clr_req;
  logic          en_q, en_d;
  trig_mode_e    mode;

  assign raw_n = {port_pin_n, irq_pin_n};

  xirq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_n),
    .dout (sync_n)
  );

  xirq_merge #(.NPORT(NPORT)) u_merge (
    .pin_n  (sync_n[0]),
    .port_n (sync_n[SW-1:1]),
    .port_en(cfg_port_en),
    .req_act(comb_act)
  );

  assign mode    = cfg_level_mode ? TRIG_EDGE_LEVEL : TRIG_EDGE;
  assign clr_req = vector_fetch | (ctl_wr & ctl_wdata_ack);

  xirq_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_act(comb_act),
    .mode   (mode),
    .clr    (clr_req),
    .pending(irq_pending)
  );

  always_comb begin
    en_d = ctl_wr ? ctl_wdata_en : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_comb begin
    ctl_rdata               = '0;
    ctl_rdata[CTL_EN_BIT]   = en_q;
    ctl_rdata[CTL_PEND_BIT] = irq_pending;
  end

  assign cpu_irq_req = irq_pending & en_q & ~cpu_imask;
  assign irq_take    = cpu_irq_req & cpu_boundary;
  assign vec_addr_hi = VEC_BASE;
  assign vec_addr_lo = VEC_BASE + VEC_W'(1);
  assign pin_level   = sync_n[0];
endmodule

// File: rtl/xirq_capture_chk.sv
module xirq_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       comb_act,
  input logic       cfg_level_mode,
  input logic       ctl_wr,
  input logic       ctl_wdata_ack,
  input logic       vector_fetch,
  input logic       cpu_imask,
  input logic       cpu_boundary,
  input logic       irq_pending,
  input logic       cpu_irq_req,
  input logic       irq_take
);
  // R2: the latch only rises after the merged request was active
  a_r2_set_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(comb_act));

  // R7: a clear with no request pending empties the latch
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_fetch || (ctl_wr && ctl_wdata_ack)) && !comb_act |=> !irq_pending);

  // R5: level mode keeps the latch set while the request is held
  a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_level_mode && comb_act |=> irq_pending);

  // R6: the CPU request needs the latch and an open mask
  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_req |-> irq_pending && !cpu_imask);

  // R6: a take needs a boundary and a request
  a_r6_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> cpu_boundary && cpu_irq_req);
endmodule

bind xirq_capture xirq_capture_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .comb_act      (comb_act),
  .cfg_level_mode(cfg_level_mode),
  .ctl_wr        (ctl_wr),
  .ctl_wdata_ack (ctl_wdata_ack),
  .vector_fetch  (vector_fetch),
  .cpu_imask     (cpu_imask),
  .cpu_boundary  (cpu_boundary),
  .irq_pending   (irq_pending),
  .cpu_irq_req   (cpu_irq_req),
  .irq_take      (irq_take)
);

// File: tb/xirq_capture_tb.sv
`timescale 1ns/1ps
module xirq_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_pin_n;
  logic [3:0]  port_pin_n;
  logic        cfg_port_en, cfg_level_mode;
  logic        ctl_wr, ctl_wdata_en, ctl_wdata_ack;
  logic        vector_fetch, cpu_imask, cpu_boundary;
  logic        irq_pending, cpu_irq_req, irq_take, pin_level;
  logic [7:0]  ctl_rdata;
  logic [10:0] vec_addr_hi, vec_addr_lo;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  xirq_capture dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin_n(port_pin_n),
    .cfg_port_en(cfg_port_en), .cfg_level_mode(cfg_level_mode),
    .ctl_wr(ctl_wr), .ctl_wdata_en(ctl_wdata_en), .ctl_wdata_ack(ctl_wdata_ack),
    .vector_fetch(vector_fetch), .cpu_imask(cpu_imask), .cpu_boundary(cpu_boundary),
    .irq_pending(irq_pending), .cpu_irq_req(cpu_irq_req), .irq_take(irq_take),
    .ctl_rdata(ctl_rdata), .vec_addr_hi(vec_addr_hi), .vec_addr_lo(vec_addr_lo),
    .pin_level(pin_level)
  );

  typedef struct packed {
    logic       pin_n;
    logic [3:0] port_n;
    logic       port_en;
    logic       level;
    logic       exp_pend;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'hF, 1'b0, 1'b0, 1'b1},  // R2 dedicated pin, edge mode
    '{1'b1, 4'hE, 1'b0, 1'b0, 1'b0},  // R3 port pin ignored when disabled
    '{1'b1, 4'hE, 1'b1, 1'b0, 1'b1},  // R3 port pin 0 enabled
    '{1'b1, 4'h7, 1'b1, 1'b1, 1'b1},  // R3 port pin 3 enabled, level mode
    '{1'b1, 4'h0, 1'b0, 1'b1, 1'b0},  // R3 all ports low but disabled
    '{1'b1, 4'hF, 1'b1, 1'b0, 1'b0},  // R3 enabled, nothing low
    '{1'b0, 4'hB, 1'b1, 1'b1, 1'b1},  // R3 pin and port together
    '{1'b1, 4'hD, 1'b1, 1'b0, 1'b1}   // R3 port pin 1
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ack(input logic en);
    ctl_wr = 1'b1; ctl_wdata_en = en; ctl_wdata_ack = 1'b1;
    tick(1);
    ctl_wr = 1'b0; ctl_wdata_ack = 1'b0;
  endtask

  task automatic idle_all();
    irq_pin_n = 1'b1; port_pin_n = 4'hF;
    tick(4);
    ack(1'b0);
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_pin_n = 1'b1; port_pin_n = 4'hF;
    cfg_port_en = 1'b0; cfg_level_mode = 1'b0;
    ctl_wr = 1'b0; ctl_wdata_en = 1'b0; ctl_wdata_ack = 1'b0;
    vector_fetch = 1'b0; cpu_imask = 1'b0; cpu_boundary = 1'b0;
    tick(3);
    @(negedge clk); rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 pending", irq_pending, 0);
    chk("R1 req", cpu_irq_req, 0);
    chk("R1 take", irq_take, 0);
    chk("R1 rdata", ctl_rdata, 8'h00);
    // R9 vectors
    chk("R9 hi", vec_addr_hi, 11'h7FA);
    chk("R9 lo", vec_addr_lo, 11'h7FB);

    // vector table walk
    for (int k = 0; k < NVEC; k++) begin
      cfg_port_en = VECS[k].port_en; cfg_level_mode = VECS[k].level;
      irq_pin_n = VECS[k].pin_n; port_pin_n = VECS[k].port_n;
      tick(4);
      chk("R3 table pending", irq_pending, VECS[k].exp_pend);
      idle_all();
      chk("R7 table cleared", irq_pending, 0);
    end
    cfg_port_en = 1'b0; cfg_level_mode = 1'b0;

    // R2/R10 exact latency
    irq_pin_n = 1'b0;
    tick(1);
    chk("R10 pin_level one edge", pin_level, 1);
    tick(1);
    chk("R10 pin_level two edges", pin_level, 0);
    chk("R2 pending not before third edge", irq_pending, 0);
    tick(1);
    chk("R2 pending at third edge", irq_pending, 1);

    // R4 edge mode: held low, ack clears, no relatch
    ack(1'b0);
    chk("R4 cleared while held", irq_pending, 0);
    tick(3);
    chk("R4 no relatch from level", irq_pending, 0);

    // R5 level mode holds through ack
    cfg_level_mode = 1'b1;
    tick(1);
    chk("R5 level sets", irq_pending, 1);
    ack(1'b0);
    chk("R5 level holds through ack", irq_pending, 1);
    vector_fetch = 1'b1; tick(1); vector_fetch = 1'b0;
    chk("R5 level holds through fetch", irq_pending, 1);
    cfg_level_mode = 1'b0;
    idle_all();

    // R7 vector fetch clears
    irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1;
    chk("R7 set before fetch", irq_pending, 1);
    tick(3);
    vector_fetch = 1'b1; tick(1); vector_fetch = 1'b0;
    chk("R7 fetch clears", irq_pending, 0);

    // R7 set wins over simultaneous ack
    irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1; tick(3);
    chk("R7 pending before race", irq_pending, 1);
    irq_pin_n = 1'b0; tick(2);
    ctl_wr = 1'b1; ctl_wdata_en = 1'b0; ctl_wdata_ack = 1'b1;
    tick(1);
    ctl_wr = 1'b0; ctl_wdata_ack = 1'b0;
    chk("R7 set wins over ack", irq_pending, 1);
    idle_all();

    // R7 set wins over simultaneous fetch
    irq_pin_n = 1'b0; tick(2);
    vector_fetch = 1'b1; tick(1); vector_fetch = 1'b0;
    chk("R7 set wins over fetch", irq_pending, 1);

    // R6 / R8 gating and readback (pending is 1)
    chk("R8 rdata pending only", ctl_rdata, 8'h08);
    chk("R6 req needs enable", cpu_irq_req, 0);
    ctl_wr = 1'b1; ctl_wdata_en = 1'b1; ctl_wdata_ack = 1'b0;
    tick(1);
    ctl_wr = 1'b0;
    chk("R8 rdata enable+pending", ctl_rdata, 8'h88);
    chk("R6 req enabled", cpu_irq_req, 1);
    chk("R6 take without boundary", irq_take, 0);
    cpu_boundary = 1'b1; #0.1;
    chk("R6 take at boundary", irq_take, 1);
    cpu_imask = 1'b1; #0.1;
    chk("R6 req masked", cpu_irq_req, 0);
    chk("R6 take masked", irq_take, 0);
    cpu_imask = 1'b0; cpu_boundary = 1'b0;
    idle_all();
    chk("R8 rdata after ack", ctl_rdata, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule